// File: doc/BRIEF.md
# Edge-Aligned PWM Channel with Buffered Compare Values

This block is one pulse-width modulation channel that produces an edge-aligned waveform. An up counter steps once for each cycle on which a clock-enable tick is high. It runs from zero to one less than the active period value, then returns to zero. The output starts each period at a level chosen by a polarity bit. It flips to the opposite level once the count reaches the active duty value. The output frequency is therefore the tick rate divided by the period value.

Software writes the period, the duty value and a control word through a narrow write port. While the channel runs, each period or duty write lands in a buffer. A polarity change is also held back. None of them reaches the compare logic until the next period boundary, so a period in progress is never cut short or glitched. While the channel is disabled, writes reach the compare logic at once. Enabling the channel starts a new period from count zero. A one-cycle pulse marks each period boundary, so the system can track when new values take hold.

Top module: `pwm_edge_chan`

## Requirements
- R1: After a synchronous reset the output and the boundary pulse are 0, the channel is disabled, and period, duty and polarity are all 0.
- R2: While enabled with period P > 0, the counter advances only on tick cycles and wraps after P ticks. `period_edge` is high for exactly one cycle per wrap, so with a tick every T cycles a boundary occurs every P*T cycles.
- R3: With polarity 0 and duty D < P, the output is high for P-D ticks of every period (start level low, high from count D).
- R4: With polarity 1 and duty D < P, the output is high for D ticks of every period (start level high, low from count D).
- R5: A duty value D >= P holds the output at the start level for the whole period. A duty value of 0 holds it at the opposite level for the whole period.
- R6: An active period of 0 holds the output at the start level, and `period_edge` pulses on every tick.
- R7: A period or duty write while enabled changes nothing in the current period. The new value takes effect from the next boundary.
- R8: A polarity change while enabled leaves the output unchanged until the next boundary. The output shows the new start level in the cycle after the boundary pulse.
- R9: While disabled, the counter is held at 0, the output sits at the polarity level, no boundary pulse occurs, and writes take effect at once. After enabling, the first boundary pulse comes P tick-steps after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable; the counter steps on cycles where it is high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Write target: 0 period, 1 duty, 2 control (bit 0 enable, bit 1 polarity), 3 unused |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered PWM waveform |
| period_edge | output | 1 | One-cycle pulse on each period boundary |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that the compare values change only through the write port, so the counter and the active values move together. The bench holds reset for three cycles, drives every input on the falling clock edge, and keeps each write to a single cycle. Duty and frequency are measured over windows that start at a boundary pulse and span whole periods. The count of high cycles is then independent of the one-cycle output register delay. Each window is taken only after at least one boundary has passed since the last configuration write.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_SPARE  = 2'd3
  } wr_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_POL_BIT = 1;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_edge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic         en_q,
  output logic [W-1:0] per_act,
  output logic [W-1:0] dty_act,
  output logic         pol_act
);
  logic [W-1:0] per_buf, dty_buf;
  logic         pol_buf;
  logic [W-1:0] per_nxt, dty_nxt;
  logic         pol_nxt;
  logic         wr_per, wr_dty, wr_ctl, commit;

  always_comb begin
    wr_per  = wr_en && (wr_sel == SEL_PERIOD);
    wr_dty  = wr_en && (wr_sel == SEL_DUTY);
    wr_ctl  = wr_en && (wr_sel == SEL_CTRL);
    per_nxt = wr_per ? wr_data : per_buf;
    dty_nxt = wr_dty ? wr_data : dty_buf;
    pol_nxt = wr_ctl ? wr_data[CTRL_POL_BIT] : pol_buf;
    commit  = load || !en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_buf <= '0;
      dty_buf <= '0;
      pol_buf <= 1'b0;
      per_act <= '0;
      dty_act <= '0;
      pol_act <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      per_buf <= per_nxt;
      dty_buf <= dty_nxt;
      pol_buf <= pol_nxt;
      if (commit) begin
        per_act <= per_nxt;
        dty_act <= dty_nxt;
        pol_act <= pol_nxt;
      end
      if (wr_ctl) en_q <= wr_data[CTRL_EN_BIT];
    end
  end

  // R7/R8: active values move only at a boundary or while disabled
  a_r7_active_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) && !$past(load)) |->
      ($stable(per_act) && $stable(dty_act) && $stable(pol_act)));
endmodule

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_top;

  always_comb begin
    at_top = (period == '0) || (cnt == period - W'(1));
    wrap   = en && tick && at_top;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)   cnt <= '0;
    else if (tick)    cnt <= wrap ? '0 : cnt + W'(1);
  end

  // R2: a nonzero count always lies below the active period
  a_r2_below_period: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (cnt < period));

  // R2: no tick, no step
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt));

  // R9: disabled channel sits at count zero
  a_r9_clear_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
endmodule

// File: rtl/pwm_level_gen.sv
module pwm_level_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] period,
  input  logic         pol,
  output logic         pwm_o,
  output logic         bnd_o
);
  logic past_duty;

  always_comb past_duty = en && (period != '0) && (cnt >= duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o <= 1'b0;
      bnd_o <= 1'b0;
    end else begin
      pwm_o <= pol ^ past_duty;
      bnd_o <= wrap;
    end
  end

  // R9: idle output equals the polarity level
  a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwm_o == $past(pol)));

  // R6: zero period keeps the start level
  a_r6_zero_period: assert property (@(posedge clk) disable iff (rst)
    (period == '0) |=> (pwm_o == $past(pol)));
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             period_edge
);
  logic             en_q, pol_act, wrap;
  logic [CNT_W-1:0] per_act, dty_act, cnt;

  pwm_cfg_regs #(.W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load(wrap), .en_q(en_q), .per_act(per_act), .dty_act(dty_act),
    .pol_act(pol_act)
  );

  pwm_cycle_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .tick(tick), .period(per_act),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_level_gen #(.W(CNT_W)) u_lvl (
    .clk(clk), .rst(rst), .en(en_q), .wrap(wrap), .cnt(cnt), .duty(dty_act),
    .period(per_act), .pol(pol_act), .pwm_o(pwm_out), .bnd_o(period_edge)
  );

  // R2: a boundary pulse coincides with a count restarted at zero
  a_r2_edge_at_zero: assert property (@(posedge clk) disable iff (rst)
    period_edge |-> (cnt == '0));
endmodule

// File: tb/pwm_edge_chan_bench.sv
module pwm_edge_chan_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, period_edge;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tdiv = 1;
  int phase = 0;
  int e_cyc = 0;
  bit done = 1'b0;

  pwm_edge_chan #(.CNT_W(8)) u_pwm_edge_chan (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out), .period_edge(period_edge)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tick = (phase == 0);
    phase = (phase + 1 >= tdiv) ? 0 : phase + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e_cyc = cyc;
  endtask

  task automatic wait_bnd();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (period_edge) break;
    end
  endtask

  task automatic measure(input int len, input int exp_hi, input int exp_bd,
                         input string tag);
    int hi = 0;
    int bd = 0;
    wait_bnd();
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      hi += pwm_out;
      bd += period_edge;
    end
    check({tag, " high"}, hi, exp_hi);
    check({tag, " edges"}, bd, exp_bd);
  endtask

  task automatic t_reset();
    check("R1 out", pwm_out, 0);
    check("R1 edge", period_edge, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); seen += pwm_out + period_edge; end
      check("R1 idle quiet", seen, 0);
    end
  endtask

  task automatic t_basic();
    tdiv = 1;
    wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, 8'b01);
    wait_bnd();
    measure(12, 9, 3, "R3 P4 D1 pol0");
    tdiv = 3;
    wait_bnd(); wait_bnd();
    measure(36, 27, 3, "R2 tick/3 freq");
    tdiv = 1;
  endtask

  task automatic t_pol1();
    wr(2'd0, 8'd5); wr(2'd1, 8'd2); wr(2'd2, 8'b11);
    wait_bnd(); wait_bnd();
    measure(15, 6, 3, "R4 P5 D2 pol1");
  endtask

  task automatic t_duty_edges();
    wr(2'd2, 8'b01); wr(2'd0, 8'd6); wr(2'd1, 8'd6);
    wait_bnd(); wait_bnd();
    measure(12, 0, 2, "R5 D=P pol0");
    wr(2'd1, 8'd0);
    wait_bnd(); wait_bnd();
    measure(12, 12, 2, "R5 D=0 pol0");
    wr(2'd1, 8'd9); wr(2'd2, 8'b11);
    wait_bnd(); wait_bnd();
    measure(12, 12, 2, "R5 D>P pol1");
  endtask

  task automatic t_zero_period();
    wr(2'd2, 8'b01); wr(2'd1, 8'd0); wr(2'd0, 8'd0);
    tdiv = 2;
    wait_bnd(); wait_bnd(); wait_bnd();
    measure(10, 0, 5, "R6 P0");
    tdiv = 1;
  endtask

  task automatic t_buffered();
    int b1, b2, b3;
    wr(2'd0, 8'd10); wr(2'd1, 8'd3);
    wait_bnd(); wait_bnd();
    wait_bnd();
    b1 = cyc;
    wr(2'd0, 8'd4); wr(2'd1, 8'd1);
    wait_bnd(); b2 = cyc;
    wait_bnd(); b3 = cyc;
    check("R7 old period kept", b2 - b1, 10);
    check("R7 new period", b3 - b2, 4);
    measure(8, 6, 2, "R7 new duty");
  endtask

  task automatic t_pol_change();
    int bad = 0;
    wr(2'd0, 8'd8); wr(2'd1, 8'd8); wr(2'd2, 8'b01);
    wait_bnd(); wait_bnd();
    wait_bnd();
    wr(2'd2, 8'b11);
    for (int i = 0; i < 20; i++) begin
      if (period_edge) break;
      bad += pwm_out;
      @(negedge clk);
    end
    check("R8 edge seen", period_edge, 1);
    check("R8 out before boundary", bad + pwm_out, 0);
    @(negedge clk);
    check("R8 new start level", pwm_out, 1);
  endtask

  task automatic t_disabled();
    int seen = 0;
    wr(2'd2, 8'b00);
    wr(2'd0, 8'd3); wr(2'd1, 8'd1);
    for (int i = 0; i < 10; i++) begin @(negedge clk); seen += pwm_out + period_edge; end
    check("R9 idle low quiet", seen, 0);
    wr(2'd2, 8'b10);
    @(negedge clk);
    check("R9 idle follows pol", pwm_out, 1);
    wr(2'd0, 8'd4); wr(2'd1, 8'd2);
    wr(2'd2, 8'b01);
    begin
      int st = e_cyc;
      wait_bnd();
      check("R9 fresh period start", cyc - st, 4);
    end
    measure(8, 4, 2, "R9 direct write P4 D2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pol1();
    t_duty_edges();
    t_zero_period();
    t_buffered();
    t_pol_change();
    t_disabled();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule